// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the device side of a four-byte serial programming link for a small controller's nonvolatile storage. A fast system clock oversamples the three link inputs: the serial clock, the data-in line and a link reset line. The block shifts in 32-bit instructions and returns one response byte for each received byte on the data-out line. It holds a word-organised flash page buffer, a four-byte EEPROM page buffer, a flash array of `FL_PAGES` pages of `PAGE_WORDS` 16-bit words, and an EEPROM array of `EE_BYTES` bytes. All of these are plain registers.

A programmer first sends the enable instruction. The block checks framing by echoing the enable instruction's second byte while the third byte arrives. If the framing is wrong, the block locks out until the link reset line is driven low. Once enabled, the programmer fills the flash buffer word by word and commits it to a page with one instruction. It can also write EEPROM bytes singly or by page, erase both arrays, read words and bytes back, and poll a busy flag that a write-busy timer holds for `BUSY_CYC` system clocks after every write or erase.

The control state machine has three states:
- `ST_WAIT_EN` (reset state): waiting for the enable instruction.
- `ST_ACTIVE`: programming commands are executed.
- `ST_LOCKED`: the enable check failed.

It has these transitions:
- `ST_WAIT_EN` to `ST_ACTIVE` when an instruction completes with bytes 0xAC, 0x53.
- `ST_WAIT_EN` to `ST_LOCKED` when any other instruction completes.
- Any state to `ST_WAIT_EN` while the link reset line is low.
- `ST_ACTIVE` and `ST_LOCKED` otherwise hold.

Top module: `isp_target`

## Requirements
- R1: The data-in line is sampled on rising serial-clock edges (MSB first), and `miso_o` changes only after a falling serial-clock edge or while `isp_rst_i` is low.
- R2: Every instruction is four bytes (b0..b3). The response shifted out during byte k (k = 1, 2, 3) is the byte received just before it, except for the reads and the poll in R8, R10 and R12. An instruction is consumed in full whatever the state.
- R3: Enable is b0 = 0xAC, b1 = 0x53. The response during b2 is 0x53, and `prog_mode_o` goes high when the instruction completes in `ST_WAIT_EN`.
- R4: If the first instruction after a link reset is not the enable instruction, the block enters `ST_LOCKED`. There it executes nothing, including a later correct enable, and `prog_mode_o` stays low.
- R5: While `isp_rst_i` is low, the bit counter is held at zero and the state returns to `ST_WAIT_EN`, so a partly sent instruction is discarded.
- R6: Flash buffer load uses b0 = 0x40 for the low byte or 0x48 for the high byte, slot b2[4:0] and data b3. A high byte is accepted only if the low byte of the same slot has been loaded since that slot's last high byte.
- R7: Flash page write (b0 = 0x4C) copies all 32 buffer slots to page b2[7:5], so that never-loaded slots give 0xFFFF. The buffer then returns to 0xFFFF with no low bytes recorded.
- R8: Flash read (b0 = 0x20 for the low byte, 0x28 for the high byte) of word address b2 (page b2[7:5], slot b2[4:0]) returns the byte during b3.
- R9: EEPROM byte write (b0 = 0xC0, address b2[5:0], data b3) replaces the old value completely, with no erase needed first.
- R10: EEPROM page load (b0 = 0xC1) puts b3 in buffer byte b2[1:0]. Page write (b0 = 0xC2) writes only the loaded bytes to addresses {b2[5:2], index} and clears the buffer. EEPROM read (b0 = 0xA0, address b2[5:0]) returns the byte during b3.
- R11: Chip erase (b0 = 0xAC, b1 = 0x80 while enabled) sets every flash word to 0xFFFF and every EEPROM byte to 0xFF.
- R12: Poll (b0 = 0xF0) returns busy in bit 0 of the response during b3. Busy rises on every accepted write or erase and lasts `BUSY_CYC` system clocks.
- R13: Flash page write, EEPROM byte or page write, and chip erase issued while busy are ignored. Buffer loads are still accepted.
- R14: After system reset, `miso_o` and `prog_mode_o` are low and every array location reads as erased (0xFFFF / 0xFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low system reset |
| isp_rst_i | input | 1 | Link reset line; low clears framing and returns to waiting for enable |
| sck_i | input | 1 | Serial clock from the programmer |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial response data out of the block |
| prog_mode_o | output | 1 | High while the block is in `ST_ACTIVE` |

## Verification
Each link input passes two synchronising flops and one edge register. A received bit therefore lands about three system clocks after a rising serial-clock edge, and a new `miso_o` bit appears about three clocks after a falling edge. The next response byte is loaded two clocks after the last rising edge of the byte before it. A command's effect on the arrays and on `prog_mode_o` follows the 32nd rising edge by about four clocks. Busy then stays set for `BUSY_CYC` clocks.

The bench holds each serial-clock level for eight system clocks. It samples `miso_o` just before each rising edge and waits ten clocks after each instruction before acting on its result. It observes every array effect through later read or poll instructions. After each write it polls until busy clears, except where it deliberately issues a command into the busy window.

// File: rtl/isp_pkg.sv
package isp_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_EN = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_LOCKED  = 2'd2
    } isp_state_e;

    localparam logic [7:0] OP_PROG     = 8'hAC;
    localparam logic [7:0] SYNC_BYTE   = 8'h53;
    localparam logic [7:0] SUB_ERASE   = 8'h80;
    localparam logic [7:0] OP_FL_LD_LO = 8'h40;
    localparam logic [7:0] OP_FL_LD_HI = 8'h48;
    localparam logic [7:0] OP_FL_WR    = 8'h4C;
    localparam logic [7:0] OP_FL_RD_LO = 8'h20;
    localparam logic [7:0] OP_FL_RD_HI = 8'h28;
    localparam logic [7:0] OP_EE_WR    = 8'hC0;
    localparam logic [7:0] OP_EE_LD    = 8'hC1;
    localparam logic [7:0] OP_EE_PG    = 8'hC2;
    localparam logic [7:0] OP_EE_RD    = 8'hA0;
    localparam logic [7:0] OP_POLL     = 8'hF0;

    typedef struct packed {
        logic       fl_ld;
        logic       fl_hi;
        logic       fl_wr;
        logic       ee_wr;
        logic       ee_ld;
        logic       ee_pg;
        logic       erase;
        logic [7:0] addr;
        logic [7:0] data;
    } mem_req_t;

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_en,
    input  logic        sck_s,
    input  logic        mosi_s,
    input  logic        tx_load,
    input  logic [7:0]  tx_byte,
    output logic [31:0] rx_word,
    output logic        byte_done,
    output logic [1:0]  byte_idx,
    output logic [4:0]  bit_cnt,
    output logic        sck_fall,
    output logic        miso
);
    logic       sck_d;
    logic       sck_rise;
    logic [7:0] tx_q;

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
            tx_q      <= '0;
            miso      <= 1'b0;
        end else if (!link_en) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            tx_q      <= '0;
            miso      <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_word <= {rx_word[30:0], mosi_s};
                bit_cnt <= bit_cnt + 5'd1;
                if (bit_cnt[2:0] == 3'd7) begin
                    byte_done <= 1'b1;
                    byte_idx  <= bit_cnt[4:3];
                end
            end
            if (tx_load) begin
                tx_q <= tx_byte;
            end else if (sck_fall) begin
                miso <= tx_q[7];
                tx_q <= {tx_q[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/isp_mem.sv
module isp_mem
    import isp_pkg::*;
#(
    parameter int PAGE_WORDS = 32,
    parameter int FL_PAGES   = 8,
    parameter int EE_BYTES   = 64,
    parameter int EE_PAGE    = 4,
    parameter int BUSY_CYC   = 2000,
    localparam int WA        = $clog2(PAGE_WORDS),
    localparam int PA        = $clog2(FL_PAGES),
    localparam int FL_WORDS  = PAGE_WORDS * FL_PAGES,
    localparam int FA        = $clog2(FL_WORDS),
    localparam int EA        = $clog2(EE_BYTES),
    localparam int EPA       = $clog2(EE_PAGE),
    localparam int BW        = $clog2(BUSY_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mem_req_t      req,
    input  logic [FA-1:0] rd_fl_addr,
    input  logic [EA-1:0] rd_ee_addr,
    output logic [15:0]   fl_rdata,
    output logic [7:0]    ee_rdata,
    output logic          busy
);
    logic [15:0]           flash [FL_WORDS];
    logic [7:0]            eeprom [EE_BYTES];
    logic [15:0]           pbuf [PAGE_WORDS];
    logic [PAGE_WORDS-1:0] lo_seen;
    logic [7:0]            ebuf [EE_PAGE];
    logic [EE_PAGE-1:0]    ebuf_vld;
    logic [BW-1:0]         busy_cnt;

    logic [WA-1:0]     fl_slot;
    logic [PA-1:0]     fl_pg;
    logic [EA-1:0]     ee_a;
    logic [EPA-1:0]    eb_a;
    logic [EA-EPA-1:0] ee_pg;

    assign fl_slot  = req.addr[WA-1:0];
    assign fl_pg    = req.addr[WA+PA-1:WA];
    assign ee_a     = req.addr[EA-1:0];
    assign eb_a     = req.addr[EPA-1:0];
    assign ee_pg    = req.addr[EA-1:EPA];
    assign busy     = (busy_cnt != '0);
    assign fl_rdata = flash[rd_fl_addr];
    assign ee_rdata = eeprom[rd_ee_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FL_WORDS; i++) flash[i] <= 16'hFFFF;
            for (int i = 0; i < EE_BYTES; i++) eeprom[i] <= 8'hFF;
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= 16'hFFFF;
            for (int i = 0; i < EE_PAGE; i++) ebuf[i] <= 8'hFF;
            lo_seen  <= '0;
            ebuf_vld <= '0;
            busy_cnt <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            // buffer loads are accepted even while busy
            if (req.fl_ld) begin
                if (!req.fl_hi) begin
                    pbuf[fl_slot][7:0] <= req.data;
                    lo_seen[fl_slot]   <= 1'b1;
                end else if (lo_seen[fl_slot]) begin
                    pbuf[fl_slot][15:8] <= req.data;
                    lo_seen[fl_slot]    <= 1'b0;
                end
            end
            if (req.ee_ld) begin
                ebuf[eb_a]     <= req.data;
                ebuf_vld[eb_a] <= 1'b1;
            end
            if (!busy) begin
                if (req.erase) begin
                    for (int i = 0; i < FL_WORDS; i++) flash[i] <= 16'hFFFF;
                    for (int i = 0; i < EE_BYTES; i++) eeprom[i] <= 8'hFF;
                    busy_cnt <= BW'(BUSY_CYC);
                end
                if (req.fl_wr) begin
                    for (int i = 0; i < FL_WORDS; i++) begin
                        if (i / PAGE_WORDS == int'(fl_pg)) flash[i] <= pbuf[i % PAGE_WORDS];
                    end
                    for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= 16'hFFFF;
                    lo_seen  <= '0;
                    busy_cnt <= BW'(BUSY_CYC);
                end
                if (req.ee_wr) begin
                    eeprom[ee_a] <= req.data;
                    busy_cnt     <= BW'(BUSY_CYC);
                end
                if (req.ee_pg) begin
                    for (int j = 0; j < EE_PAGE; j++) begin
                        if (ebuf_vld[j]) eeprom[EA'(int'(ee_pg) * EE_PAGE + j)] <= ebuf[j];
                        ebuf[j] <= 8'hFF;
                    end
                    ebuf_vld <= '0;
                    busy_cnt <= BW'(BUSY_CYC);
                end
            end
        end
    end
endmodule

// File: rtl/isp_target.sv
module isp_target
    import isp_pkg::*;
#(
    parameter int PAGE_WORDS = 32,
    parameter int FL_PAGES   = 8,
    parameter int EE_BYTES   = 64,
    parameter int EE_PAGE    = 4,
    parameter int BUSY_CYC   = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic isp_rst_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic prog_mode_o
);
    localparam int FA = $clog2(PAGE_WORDS * FL_PAGES);
    localparam int EA = $clog2(EE_BYTES);

    logic [2:0]  sync_v;
    logic        link_en, mosi_s, sck_s;
    logic [31:0] rx_word;
    logic        byte_done, sck_fall, cmd_done;
    logic [1:0]  byte_idx;
    logic [4:0]  bit_cnt;
    logic        tx_load;
    logic [7:0]  tx_byte, resp;
    logic [15:0] fl_rdata;
    logic [7:0]  ee_rdata;
    logic        busy;
    logic [7:0]  b0, b1;
    mem_req_t    mreq;
    isp_state_e  state_q, state_d;

    isp_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({isp_rst_i, mosi_i, sck_i}),
        .sync_o  (sync_v)
    );
    assign link_en = sync_v[2];
    assign mosi_s  = sync_v[1];
    assign sck_s   = sync_v[0];

    isp_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en   (link_en),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .rx_word   (rx_word),
        .byte_done (byte_done),
        .byte_idx  (byte_idx),
        .bit_cnt   (bit_cnt),
        .sck_fall  (sck_fall),
        .miso      (miso_o)
    );

    isp_mem #(
        .PAGE_WORDS (PAGE_WORDS),
        .FL_PAGES   (FL_PAGES),
        .EE_BYTES   (EE_BYTES),
        .EE_PAGE    (EE_PAGE),
        .BUSY_CYC   (BUSY_CYC)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (mreq),
        .rd_fl_addr (rx_word[FA-1:0]),
        .rd_ee_addr (rx_word[EA-1:0]),
        .fl_rdata   (fl_rdata),
        .ee_rdata   (ee_rdata),
        .busy       (busy)
    );

    // a full instruction sits in rx_word as {b0, b1, b2, b3}
    assign cmd_done = byte_done && (byte_idx == 2'd3);
    assign b0       = rx_word[31:24];
    assign b1       = rx_word[23:16];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_EN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_EN: begin
                if (cmd_done) begin
                    state_d = (b0 == OP_PROG && b1 == SYNC_BYTE) ? ST_ACTIVE : ST_LOCKED;
                end
            end
            ST_ACTIVE: state_d = ST_ACTIVE;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_WAIT_EN;
        endcase
        if (!link_en) state_d = ST_WAIT_EN;
    end

    // outputs: command strobes, response selection, mode flag
    always_comb begin
        mreq      = '0;
        mreq.addr = rx_word[15:8];
        mreq.data = rx_word[7:0];
        if (cmd_done && link_en && state_q == ST_ACTIVE) begin
            unique case (b0)
                OP_PROG:     mreq.erase = (b1 == SUB_ERASE);
                OP_FL_LD_LO: mreq.fl_ld = 1'b1;
                OP_FL_LD_HI: begin mreq.fl_ld = 1'b1; mreq.fl_hi = 1'b1; end
                OP_FL_WR:    mreq.fl_wr = 1'b1;
                OP_EE_WR:    mreq.ee_wr = 1'b1;
                OP_EE_LD:    mreq.ee_ld = 1'b1;
                OP_EE_PG:    mreq.ee_pg = 1'b1;
                default:     mreq.erase = 1'b0;
            endcase
        end

        // after byte 2 the lower 24 bits hold {b0, b1, b2}
        resp = rx_word[7:0];
        if (byte_idx == 2'd2 && state_q == ST_ACTIVE) begin
            unique case (rx_word[23:16])
                OP_FL_RD_LO: resp = fl_rdata[7:0];
                OP_FL_RD_HI: resp = fl_rdata[15:8];
                OP_EE_RD:    resp = ee_rdata;
                OP_POLL:     resp = {7'd0, busy};
                default:     resp = rx_word[7:0];
            endcase
        end

        prog_mode_o = (state_q == ST_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_load <= byte_done;
            if (byte_done) tx_byte <= resp;
        end
    end
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk
    import isp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       link_en,
    input logic       sck_fall,
    input logic       miso_o,
    input logic       prog_mode_o,
    input logic       cmd_done,
    input logic [7:0] b1,
    input logic [4:0] bit_cnt,
    input logic       busy,
    input mem_req_t   mreq,
    input isp_state_e state_q
);
    logic wr_any;
    assign wr_any = mreq.fl_wr | mreq.ee_wr | mreq.ee_pg | mreq.erase;

    p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_o) |-> ($past(sck_fall) || !$past(link_en)));

    p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode_o) |-> ($past(cmd_done) && $past(b1) == SYNC_BYTE));

    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && link_en) |=> state_q == ST_LOCKED);

    p_link_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (bit_cnt == 5'd0 && !prog_mode_o));

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_any));

    p_busy_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_any) |=> busy);
endmodule

bind isp_target isp_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_en     (link_en),
    .sck_fall    (sck_fall),
    .miso_o      (miso_o),
    .prog_mode_o (prog_mode_o),
    .cmd_done    (cmd_done),
    .b1          (b1),
    .bit_cnt     (bit_cnt),
    .busy        (busy),
    .mreq        (mreq),
    .state_q     (state_q)
);

// File: tb/isp_target_bench.sv
module isp_target_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic isp_rst_i = 1'b0;
    logic sck_i = 1'b0;
    logic mosi_i = 1'b0;
    logic miso_o, prog_mode_o;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] fm [256];
    logic [7:0]  em [64];
    logic [15:0] pb [32];
    logic [31:0] lo_m;
    logic [7:0]  eb [4];
    logic [3:0]  ev;

    always #5 clk = ~clk;

    isp_target #(.BUSY_CYC(2000)) u_isp_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .isp_rst_i   (isp_rst_i),
        .sck_i       (sck_i),
        .mosi_i      (mosi_i),
        .miso_o      (miso_o),
        .prog_mode_o (prog_mode_o)
    );

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic xbit(input logic d, output logic q);
        mosi_i = d;
        repeat (HALF) @(negedge clk);
        q = miso_o;
        sck_i = 1'b1;
        repeat (HALF) @(negedge clk);
        sck_i = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
        for (int i = 7; i >= 0; i--) xbit(d[i], q[i]);
    endtask

    task automatic send(input logic [7:0] a, b, c, d,
                        output logic [7:0] r1, r2, r3);
        logic [7:0] r0;
        xbyte(a, r0);
        xbyte(b, r1);
        xbyte(c, r2);
        xbyte(d, r3);
        repeat (10) @(negedge clk);
    endtask

    task automatic link_pulse();
        isp_rst_i = 1'b0;
        repeat (20) @(negedge clk);
        isp_rst_i = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    // bench model of an accepted array/buffer command
    task automatic model(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d);
        case (op)
            8'h40: begin pb[a[4:0]][7:0] = d; lo_m[a[4:0]] = 1'b1; end
            8'h48: if (lo_m[a[4:0]]) begin pb[a[4:0]][15:8] = d; lo_m[a[4:0]] = 1'b0; end
            8'h4C: begin
                for (int w = 0; w < 32; w++) begin fm[{a[7:5], 5'(w)}] = pb[w]; pb[w] = 16'hFFFF; end
                lo_m = '0;
            end
            8'hC0: em[a[5:0]] = d;
            8'hC1: begin eb[a[1:0]] = d; ev[a[1:0]] = 1'b1; end
            8'hC2: begin
                for (int j = 0; j < 4; j++) begin
                    if (ev[j]) em[{a[5:2], 2'(j)}] = eb[j];
                    eb[j] = 8'hFF;
                end
                ev = '0;
            end
            default: ;
        endcase
    endtask

    task automatic cmd(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r1, r2, r3;
        send(op, 8'h00, a, d, r1, r2, r3);
        model(op, a, d);
    endtask

    task automatic wait_ready();
        logic [7:0] r1, r2, r3;
        for (int k = 0; k < 10; k++) begin
            send(8'hF0, 8'h00, 8'h00, 8'h00, r1, r2, r3);
            if (r3[0] == 1'b0) break;
        end
    endtask

    task automatic rd_fl(input logic [7:0] a, output logic [15:0] w);
        logic [7:0] r1, r2, r3;
        send(8'h20, 8'h00, a, 8'h00, r1, r2, r3);
        w[7:0] = r3;
        send(8'h28, 8'h00, a, 8'h00, r1, r2, r3);
        w[15:8] = r3;
    endtask

    task automatic rd_ee(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] r1, r2;
        send(8'hA0, 8'h00, a, 8'h00, r1, r2, v);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0]  r1, r2, r3, v;
        logic [15:0] w;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) fm[i] = 16'hFFFF;
        for (int i = 0; i < 64; i++) em[i] = 8'hFF;
        for (int i = 0; i < 32; i++) pb[i] = 16'hFFFF;
        for (int i = 0; i < 4; i++) eb[i] = 8'hFF;
        lo_m = '0;
        ev = '0;

        repeat (5) @(negedge clk);
        chk("R14 miso", 16'(miso_o), 16'h0);
        chk("R14 prog_mode", 16'(prog_mode_o), 16'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        isp_rst_i = 1'b1;
        repeat (20) @(negedge clk);

        // R4: bad framing locks; a write and a correct enable are then ignored
        send(8'hAC, 8'h55, 8'h00, 8'h00, r1, r2, r3);
        chk("R4 locked prog_mode", 16'(prog_mode_o), 16'h0);
        send(8'hC0, 8'h00, 8'h05, 8'hAA, r1, r2, r3);
        send(8'hAC, 8'h53, 8'h00, 8'h00, r1, r2, r3);
        chk("R4 enable ignored", 16'(prog_mode_o), 16'h0);

        // R3 / R2: enable after link reset, echo of bytes
        link_pulse();
        send(8'hAC, 8'h53, 8'h00, 8'h00, r1, r2, r3);
        chk("R2 echo b0", 16'(r1), 16'h00AC);
        chk("R3 echo sync", 16'(r2), 16'h0053);
        chk("R3 prog_mode", 16'(prog_mode_o), 16'h1);
        rd_ee(8'h05, v);
        chk("R4 write while locked", 16'(v), 16'h00FF);

        // R5: partial instruction then link reset restores framing
        for (int i = 0; i < 3; i++) xbit(1'b1, r1[0]);
        link_pulse();
        chk("R5 mode cleared", 16'(prog_mode_o), 16'h0);
        send(8'hAC, 8'h53, 8'h00, 8'h00, r1, r2, r3);
        chk("R5 reframe echo", 16'(r2), 16'h0053);
        chk("R5 reframe mode", 16'(prog_mode_o), 16'h1);

        rd_fl(8'h00, w);
        chk("R14 flash erased", w, 16'hFFFF);

        // R6: high before low is dropped
        cmd(8'h48, 8'h03, 8'h12);
        cmd(8'h40, 8'h03, 8'h34);
        cmd(8'h4C, 8'h40, 8'h00);
        wait_ready();
        rd_fl(8'h43, w);
        chk("R6 high ignored", w, 16'hFF34);
        rd_fl(8'h43, w);
        chk("R8 model page2 slot3", w, fm[8'h43]);

        // R7: full word, and buffer reset after commit
        cmd(8'h40, 8'h05, 8'h56);
        cmd(8'h48, 8'h05, 8'h78);
        cmd(8'h4C, 8'h20, 8'h00);
        // R13: EEPROM write inside busy window
        send(8'hC0, 8'h00, 8'h07, 8'h3C, r1, r2, r3);
        send(8'hF0, 8'h00, 8'h00, 8'h00, r1, r2, r3);
        chk("R12 busy after write", 16'(r3[0]), 16'h1);
        wait_ready();
        send(8'hF0, 8'h00, 8'h00, 8'h00, r1, r2, r3);
        chk("R12 busy cleared", 16'(r3[0]), 16'h0);
        rd_ee(8'h07, v);
        chk("R13 write while busy", 16'(v), 16'h00FF);
        rd_fl(8'h25, w);
        chk("R7 committed word", w, 16'h7856);
        rd_fl(8'h23, w);
        chk("R7 buffer reset", w, 16'hFFFF);

        // R9: overwrite without erase
        cmd(8'hC0, 8'h0A, 8'h0F);
        wait_ready();
        cmd(8'hC0, 8'h0A, 8'hF0);
        wait_ready();
        rd_ee(8'h0A, v);
        chk("R9 overwrite", 16'(v), 16'h00F0);

        // R10: partial EEPROM page
        cmd(8'hC1, 8'h00, 8'h11);
        cmd(8'hC1, 8'h02, 8'h22);
        cmd(8'hC2, 8'h0C, 8'h00);
        wait_ready();
        for (int j = 0; j < 4; j++) begin
            rd_ee(8'(12 + j), v);
            chk("R10 page byte", 16'(v), 16'(em[12 + j]));
        end
        rd_ee(8'h0D, v);
        chk("R10 unloaded byte", 16'(v), 16'h00FF);

        // random pages and bytes against the model
        for (int it = 0; it < 5; it++) begin
            logic [7:0] pg, sl, ea, ed;
            logic [7:0] slots [4];
            pg = 8'($urandom_range(0, 7));
            for (int k = 0; k < 4; k++) begin
                sl = 8'($urandom_range(0, 31));
                slots[k] = sl;
                cmd(8'h40, sl, 8'($urandom));
                cmd(8'h48, sl, 8'($urandom));
            end
            cmd(8'h4C, {pg[2:0], 5'd0}, 8'h00);
            wait_ready();
            for (int k = 0; k < 4; k++) begin
                rd_fl({pg[2:0], slots[k][4:0]}, w);
                chk("R7 random word", w, fm[{pg[2:0], slots[k][4:0]}]);
            end
            ea = 8'($urandom_range(0, 63));
            ed = 8'($urandom);
            cmd(8'hC0, ea, ed);
            wait_ready();
            rd_ee(ea, v);
            chk("R9 random byte", 16'(v), 16'(em[ea[5:0]]));
        end

        // R11: chip erase
        send(8'hAC, 8'h80, 8'h00, 8'h00, r1, r2, r3);
        wait_ready();
        rd_fl(8'h25, w);
        chk("R11 flash erased", w, 16'hFFFF);
        rd_ee(8'h0A, v);
        chk("R11 eeprom erased", 16'(v), 16'h00FF);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule